// File: doc/BRIEF.md
# Serial ADC Readout Master

This block reads 12-bit conversion results from a serial analog-to-digital converter over a three-wire link: an active-low select, a serial clock and a data line driven by the converter. The serial clock rests low between frames. A one-cycle `start` pulse opens a frame. The master pulls select low and waits a parameterised number of system clocks before the first clock edge. It then runs the serial clock from a divider and samples the data line on each rising edge.

The converter changes its output on falling edges. With the clock resting low, the first edge after select falls is a rising edge, and it picks up an extra zero that the converter never clocked out. The master therefore discards four leading bits rather than three. It shifts the next twelve bits in, most significant first. After the last rising edge the clock returns low and select is released on that same cycle. The result then appears with a single-cycle valid strobe. A quiet interval follows before a new frame can start. As an option, the master checks that the four discarded bits were all zero and raises a sticky flag if any was one.

Top module: `adc_rd_master`

## Requirements
- R1: After reset `adc_cs_n` is 1 and `adc_sclk`, `busy`, `rd_valid` and `lead_err` are 0; whenever `busy` is 0, `adc_cs_n` is 1.
- R2: A `start` seen while idle pulls `adc_cs_n` low and raises `busy` on the next cycle. The first rising edge of `adc_sclk` comes exactly `EN_CYC + HALF_CYC` system clocks after `adc_cs_n` falls.
- R3: Once running, `adc_sclk` holds each level for `HALF_CYC` system clocks and makes exactly `FRAME_LEN` (16) rising edges per frame.
- R4: `adc_sdi` is sampled on each rising edge of `adc_sclk`. Samples 1 to 4 are discarded. Samples 5 to 16 form `rd_data` bit 11 down to bit 0.
- R5: On the cycle `adc_sclk` falls after the last rising edge, `adc_cs_n` returns to 1 and `rd_valid` is 1 for exactly one cycle, with `rd_data` holding the result.
- R6: `busy` stays 1 for `QUIET_CYC` cycles after `adc_cs_n` rises. A `start` that arrives while `busy` is 1 has no effect.
- R7: If any of the four discarded samples is 1, `lead_err` becomes 1. It stays 1 until reset, and the data bits are still delivered.
- R8: `adc_sclk` is never 1 while `adc_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to read one conversion |
| busy | output | 1 | Frame or quiet interval in progress |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Serial clock, rests low |
| adc_sdi | input | 1 | Serial data from converter |
| rd_valid | output | 1 | One-cycle strobe marking a new result |
| rd_data | output | DATA_W | Assembled result, MSB first on the wire |
| lead_err | output | 1 | Sticky flag: a discarded leading bit was 1 |

## Verification
The assertions assume `start` is a synchronous pulse and that `adc_sdi` changes only after a falling edge of `adc_sclk` or a falling edge of select, never on the system edge where a rising edge is sampled. The bench converter model respects this. It updates its data line from the select and serial clock edges, which the master produces at posedges of `clk`, so the line settles at least `HALF_CYC` system clocks before it is sampled. Leading-one faults are injected only on the four discarded bit positions. A `start` is sent during `busy` only well inside a frame, so the model's frame schedule is not disturbed.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ENWAIT = 2'd1,
      ST_CLOCK  = 2'd2,
      ST_QUIET  = 2'd3
   } rd_state_e;
endpackage

// File: rtl/adc_rd_divider.sv
module adc_rd_divider #(
   parameter int HALF_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   generate
      if (HALF_CYC < 1) begin : g_bad
         $error("adc_rd_divider: HALF_CYC must be at least 1");
      end
      if (HALF_CYC == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (!run)         cnt <= '0;
            else if (cnt == LAST)  cnt <= '0;
            else                   cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/adc_rd_assembler.sv
module adc_rd_assembler #(
   parameter int DATA_W     = 12,
   parameter int LEAD       = 4,
   parameter int FRAME_LEN  = 16,
   parameter bit LEAD_CHECK = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           rise,
   input  logic [$clog2(FRAME_LEN+1)-1:0] rise_idx,
   input  logic                           sdi,
   output logic [DATA_W-1:0]              data,
   output logic                           lead_err
);
   localparam int IW = $clog2(FRAME_LEN + 1);
   localparam logic [IW-1:0] FIRST_DATA = IW'(LEAD);
   localparam logic [IW-1:0] END_DATA   = IW'(LEAD + DATA_W);

   logic [DATA_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shreg <= '0;
      else if (rise && rise_idx >= FIRST_DATA && rise_idx < END_DATA)
         shreg <= {shreg[DATA_W-2:0], sdi};
   end
   assign data = shreg;

   generate
      if (LEAD_CHECK) begin : g_check
         logic err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  err_q <= 1'b0;
            else if (rise && rise_idx < FIRST_DATA && sdi) err_q <= 1'b1;
         end
         assign lead_err = err_q;

         AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            lead_err |=> lead_err) else $error("lead_err dropped"); // R7
      end else begin : g_nocheck
         assign lead_err = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/adc_rd_master.sv
module adc_rd_master
   import adc_rd_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int LEAD_ZEROS = 4,
   parameter int FRAME_LEN  = 16,
   parameter int HALF_CYC   = 2,
   parameter int EN_CYC     = 2,
   parameter int QUIET_CYC  = 4,
   parameter int CLK_MHZ    = 50,
   parameter int EN_MIN_NS  = 20,
   parameter bit LEAD_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              adc_cs_n,
   output logic              adc_sclk,
   input  logic              adc_sdi,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              lead_err
);
   localparam int CNT_MAX = (EN_CYC > QUIET_CYC) ? EN_CYC : QUIET_CYC;
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam int IW      = $clog2(FRAME_LEN + 1);
   localparam logic [CW-1:0] EN_LAST    = CW'(EN_CYC - 1);
   localparam logic [CW-1:0] QUIET_LAST = CW'(QUIET_CYC - 1);
   localparam logic [IW-1:0] RISE_ALL   = IW'(FRAME_LEN);

   generate
      if (EN_CYC < 1 || QUIET_CYC < 1) begin : g_bad_cnt
         $error("adc_rd_master: EN_CYC and QUIET_CYC must be at least 1");
      end
      if (FRAME_LEN < LEAD_ZEROS + DATA_W) begin : g_bad_frame
         $error("adc_rd_master: FRAME_LEN too short for leading zeros plus data");
      end
      if ((EN_CYC + HALF_CYC) * 1000 < EN_MIN_NS * CLK_MHZ) begin : g_bad_en
         $error("adc_rd_master: select-to-first-edge time below minimum");
      end
   endgenerate

   rd_state_e     state;
   logic [CW-1:0] cnt;
   logic [IW-1:0] rise_idx;
   logic          sclk_q, cs_n_q, valid_q;
   logic          tick, rise;

   adc_rd_divider #(.HALF_CYC(HALF_CYC)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state == ST_CLOCK),
      .tick (tick)
   );

   assign rise = (state == ST_CLOCK) && tick && !sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         rise_idx <= '0;
         sclk_q   <= 1'b0;
         cs_n_q   <= 1'b1;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               state    <= ST_ENWAIT;
               cnt      <= '0;
               rise_idx <= '0;
               cs_n_q   <= 1'b0;
            end
            ST_ENWAIT: begin
               if (cnt == EN_LAST) begin
                  state <= ST_CLOCK;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CLOCK: if (tick) begin
               if (!sclk_q) begin
                  sclk_q   <= 1'b1;
                  rise_idx <= rise_idx + 1'b1;
               end else begin
                  sclk_q <= 1'b0;
                  if (rise_idx == RISE_ALL) begin
                     state   <= ST_QUIET;
                     cs_n_q  <= 1'b1;
                     valid_q <= 1'b1;
                     cnt     <= '0;
                  end
               end
            end
            ST_QUIET: begin
               if (cnt == QUIET_LAST) state <= ST_IDLE;
               else                   cnt   <= cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   adc_rd_assembler #(
      .DATA_W    (DATA_W),
      .LEAD      (LEAD_ZEROS),
      .FRAME_LEN (FRAME_LEN),
      .LEAD_CHECK(LEAD_CHECK)
   ) u_asm (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (rise),
      .rise_idx(rise_idx),
      .sdi     (adc_sdi),
      .data    (rd_data),
      .lead_err(lead_err)
   );

   assign busy     = (state != ST_IDLE);
   assign adc_cs_n = cs_n_q;
   assign adc_sclk = sclk_q;
   assign rd_valid = valid_q;

   AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n |-> !adc_sclk) else $error("sclk high while deselected"); // R8
   AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> adc_cs_n) else $error("select low while idle"); // R1
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid) else $error("valid longer than one cycle"); // R5
   AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_cs_n) |-> rd_valid) else $error("select released without valid"); // R5
   AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_cs_n) |-> busy) else $error("busy low at select release"); // R6
   AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !adc_cs_n) |=> busy) else $error("busy dropped mid-frame"); // R6
endmodule

// File: tb/adc_rd_master_test.sv
`timescale 1ns/1ps
module adc_rd_master_test;
   localparam int HALF = 2;
   localparam int EN   = 2;
   localparam int QT   = 4;
   localparam int DW   = 12;
   localparam int PER  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic adc_sdi = 1'b0;
   logic busy, adc_cs_n, adc_sclk, rd_valid, lead_err;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int errors = 0;

   always #(PER/2) clk = ~clk;

   adc_rd_master #(.HALF_CYC(HALF), .EN_CYC(EN), .QUIET_CYC(QT)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
      .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdi(adc_sdi),
      .rd_valid(rd_valid), .rd_data(rd_data), .lead_err(lead_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // converter model: output changes on select fall and on sclk falls
   logic [DW-1:0] word = '0;
   int  inj = -1;
   int  fcnt = 0;
   bit  in_frame = 1'b0;
   always @(negedge adc_cs_n, posedge adc_cs_n, negedge adc_sclk) begin
      if (adc_cs_n) begin
         in_frame = 1'b0;
      end else if (!in_frame) begin
         in_frame = 1'b1;
         fcnt = 0;
         adc_sdi = (inj == 0);
      end else if (fcnt < 15) begin
         fcnt++;
         adc_sdi = (fcnt < 4) ? (inj == fcnt) : word[15-fcnt];
      end
   end

   // edge counting and select-to-first-edge timing
   int rises = 0;
   longint t_cs = 0;
   always @(negedge adc_cs_n, posedge adc_sclk) begin
      if (adc_sclk) begin
         rises++;
         if (rises == 1)
            chk(($time - t_cs) == longint'((EN + HALF) * PER), "R2",
                "first rise delay ns", $time - t_cs, (EN + HALF) * PER);
      end else begin
         rises = 0;
         t_cs = $time;
      end
   end

   // reference schedule: entries {cs_n, sclk, busy, valid}
   logic [3:0] q[$];
   logic [3:0] exp_now = 4'b1000;
   bit exp_err = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         exp_now = 4'b1000;
      end else begin
         if (q.size() == 0 && start) begin
            for (int i = 0; i < EN + HALF; i++) q.push_back(4'b0010);
            for (int k = 1; k < 32; k++)
               for (int i = 0; i < HALF; i++) q.push_back({1'b0, k[0], 2'b10});
            q.push_back(4'b1011);
            for (int i = 1; i < QT; i++) q.push_back(4'b1010);
         end
         if (q.size() != 0) exp_now = q.pop_front();
         else               exp_now = 4'b1000;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(adc_cs_n == exp_now[3], "R2", "adc_cs_n", adc_cs_n, exp_now[3]);
         chk(adc_sclk == exp_now[2], "R3", "adc_sclk", adc_sclk, exp_now[2]);
         chk(busy     == exp_now[1], "R6", "busy",     busy,     exp_now[1]);
         chk(rd_valid == exp_now[0], "R5", "rd_valid", rd_valid, exp_now[0]);
         chk(!(adc_cs_n && adc_sclk), "R8", "sclk while deselected", adc_sclk, 0);
         if (rd_valid) begin
            chk(rd_data == word, "R4", "rd_data", rd_data, word);
            chk(rises == 16, "R3", "rising edges", rises, 16);
            chk(lead_err == exp_err, "R7", "lead_err", lead_err, exp_err);
         end
      end
   end

   task automatic run_frame(input logic [DW-1:0] w, input int bad, input bit poke);
      do @(negedge clk); while (busy);
      word = w;
      inj  = bad;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (6) @(negedge clk);
         start = 1'b1;             // R6: ignored while busy
         @(negedge clk);
         start = 1'b0;
      end
      do @(negedge clk); while (!rd_valid);
      if (bad >= 0) exp_err = 1'b1;
      do @(negedge clk); while (busy);
      repeat (3) @(negedge clk);   // stays deselected after a poked start
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(adc_cs_n == 1'b1, "R1", "reset cs_n", adc_cs_n, 1);
      chk(adc_sclk == 1'b0, "R1", "reset sclk", adc_sclk, 0);
      chk(busy == 1'b0, "R1", "reset busy", busy, 0);
      chk(rd_valid == 1'b0, "R1", "reset valid", rd_valid, 0);
      chk(lead_err == 1'b0, "R1", "reset lead_err", lead_err, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_frame(12'hA5C, -1, 1'b0);
      run_frame(12'hFFF, -1, 1'b1);
      run_frame(12'h000, -1, 1'b0);
      run_frame(12'h801, -1, 1'b1);
      run_frame(12'h7FE, -1, 1'b0);
      chk(lead_err == 1'b0, "R7", "clean frames keep lead_err low", lead_err, 0);
      run_frame(12'h3C3, 0, 1'b0);   // R7: unprepared first bit forced high
      chk(lead_err == 1'b1, "R7", "lead_err after fault", lead_err, 1);
      run_frame(12'h155, -1, 1'b0);  // sticky across a clean frame
      chk(lead_err == 1'b1, "R7", "lead_err sticky", lead_err, 1);
      rst_n = 1'b0;
      exp_err = 1'b0;
      repeat (2) @(negedge clk);
      chk(lead_err == 1'b0, "R1", "reset clears lead_err", lead_err, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_frame(12'h924, 3, 1'b0);   // R7: last discarded bit high
      chk(lead_err == 1'b1, "R7", "lead_err from fourth bit", lead_err, 1);
      run_frame(12'h0F0, -1, 1'b1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule